// File: doc/BRIEF.md
# LRU Tag CAM with Per-Entry State

A small associative store of sixteen 32-bit tags. Each tag slot carries a 4-bit state nibble. A least-recently-used ordering is kept over the slots. Four operations share one request port: a tag lookup, a full slot write (tag plus state), a state-only write and a state-only read. Each request is accepted in one cycle. Its response appears, registered, on the following cycle.

A lookup that hits returns the matching slot and its state. If several slots hold the tag, the lowest slot index wins. The hit also moves that slot to the most-recent end of the ordering. A lookup that misses returns the least-recently-used slot as the replacement candidate, so the caller can follow up with a full write to that slot. A full write also refreshes the ordering. The state-only operations never touch it.

Top module: `tag_cam_lru`

## Requirements
- R1: After reset, rsp_valid is 0, every tag and every state is 0, and the ordering from least to most recent is slot 0 up to slot 15.
- R2: rsp_valid is 1 exactly one cycle after a cycle with req_valid=1, and 0 one cycle after a cycle with req_valid=0.
- R3: A lookup (req_op=2'b00) whose req_tag matches a stored tag responds with rsp_hit=1, rsp_idx set to the matching slot and rsp_state set to that slot's state.
- R4: A lookup that matches no slot responds with rsp_hit=0, rsp_idx set to the least-recently-used slot and rsp_state=0.
- R5: A lookup hit makes the hit slot the most recently used. A lookup miss leaves the ordering unchanged.
- R6: A full write (req_op=2'b01) stores req_tag and req_state into slot req_idx and makes that slot the most recently used. Its response is rsp_hit=0, rsp_idx=req_idx and rsp_state=req_state.
- R7: A state write (req_op=2'b10) replaces only the state of slot req_idx. The tag and the ordering are left unchanged. Its response is rsp_hit=0, rsp_idx=req_idx and rsp_state=req_state.
- R8: A state read (req_op=2'b11) responds with rsp_hit=0, rsp_idx=req_idx and the state of that slot. It changes neither the contents nor the ordering.
- R9: When several slots hold the looked-up tag, the lowest slot index is reported and refreshed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 00 lookup, 01 full write, 10 state write, 11 state read |
| req_idx | input | 4 | Target slot for the write and read operations |
| req_tag | input | 32 | Tag to look up or to store |
| req_state | input | 4 | State to store |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_hit | output | 1 | Lookup matched |
| rsp_idx | output | 4 | Matching slot, replacement candidate, or target slot |
| rsp_state | output | 4 | State returned or written |

## Verification
Several properties are checked on every cycle by the assertions:
- the one-cycle response timing;
- that the ordering always stays a permutation of the sixteen slots;
- that a refreshed slot lands at the most-recent end;
- that a miss carries a zero state and only lookups can report a hit;
- that written states are held.

Other properties only the bench scenarios can show, because they need the ordering to be tracked across a long history and compared against an independent model:
- which slot a miss names after mixed traffic;
- that the state-only operations leave the ordering untouched;
- lowest-index priority among duplicate tags.

// File: rtl/tag_cam_pkg.sv
package tag_cam_pkg;
  typedef enum logic [1:0] {
    OP_LOOKUP = 2'b00,
    OP_WRITE  = 2'b01,
    OP_STWR   = 2'b10,
    OP_STRD   = 2'b11
  } cam_op_e;
endpackage

// File: rtl/tag_cam_prienc.sv
module tag_cam_prienc #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  match_vec,
  output logic          any_match,
  output logic [IW-1:0] first_idx
);
  always_comb begin
    first_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match_vec[i]) first_idx = IW'(i);
    end
    any_match = |match_vec;
  end
endmodule

// File: rtl/tag_cam_store.sv
module tag_cam_store #(
  parameter int N    = 16,
  parameter int TW   = 32,
  parameter int SW   = 4,
  parameter int IW   = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_tag_en,
  input  logic          wr_st_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [TW-1:0] wr_tag,
  input  logic [SW-1:0] wr_st,
  input  logic [TW-1:0] cmp_tag,
  output logic [N-1:0]  match_vec,
  input  logic [IW-1:0] rd_idx,
  output logic [SW-1:0] rd_st
);
  logic [TW-1:0] tag_q [N];
  logic [TW-1:0] tag_d [N];
  logic [SW-1:0] st_q  [N];
  logic [SW-1:0] st_d  [N];

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_slot
      assign match_vec[g] = (tag_q[g] == cmp_tag);

      always_comb begin
        tag_d[g] = tag_q[g];
        st_d[g]  = st_q[g];
        if (wr_tag_en && wr_idx == IW'(g)) tag_d[g] = wr_tag;
        if (wr_st_en  && wr_idx == IW'(g)) st_d[g]  = wr_st;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          tag_q[g] <= '0;
          st_q[g]  <= '0;
        end else begin
          tag_q[g] <= tag_d[g];
          st_q[g]  <= st_d[g];
        end
      end
    end
  endgenerate

  assign rd_st = st_q[rd_idx];

  // R7: a state write is visible in the addressed slot on the next cycle
  p_state_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_st_en |=> st_q[$past(wr_idx)] == $past(wr_st));
  // R6: a full write lands its tag
  p_tag_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tag_en |=> tag_q[$past(wr_idx)] == $past(wr_tag));
endmodule

// File: rtl/tag_cam_order.sv
module tag_cam_order #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch_en,
  input  logic [IW-1:0] touch_idx,
  output logic [IW-1:0] lru_idx
);
  // position 0 is least recent, position N-1 most recent
  logic [IW-1:0] ord_q [N];
  logic [IW-1:0] ord_d [N];
  logic [N-1:0]  at_pos;
  logic [N-1:0]  passed;
  logic [N-1:0]  cover_mask;

  always_comb begin
    for (int p = 0; p < N; p++) at_pos[p] = (ord_q[p] == touch_idx);
    passed[0] = at_pos[0];
    for (int p = 1; p < N; p++) passed[p] = passed[p-1] | at_pos[p];
  end

  always_comb begin
    for (int p = 0; p < N; p++) ord_d[p] = ord_q[p];
    if (touch_en) begin
      for (int p = 0; p < N - 1; p++) begin
        if (passed[p]) ord_d[p] = ord_q[p+1];
      end
      ord_d[N-1] = touch_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < N; p++) ord_q[p] <= IW'(p);
    end else if (touch_en) begin
      for (int p = 0; p < N; p++) ord_q[p] <= ord_d[p];
    end
  end

  assign lru_idx = ord_q[0];

  always_comb begin
    cover_mask = '0;
    for (int p = 0; p < N; p++) cover_mask[ord_q[p]] = 1'b1;
  end

  // R5: the ordering stays a permutation of all slots
  p_perm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    &cover_mask);
  // R5: a refreshed slot becomes most recent
  p_touch_mru_r5: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> ord_q[N-1] == $past(touch_idx));
  // R5: without a refresh, the victim does not move
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !touch_en |=> $stable(lru_idx));
endmodule

// File: rtl/tag_cam_lru.sv
module tag_cam_lru #(
  parameter int NUM_ENT = 16,
  parameter int TAG_W   = 32,
  parameter int ST_W    = 4,
  localparam int IDX_W  = $clog2(NUM_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  input  logic [IDX_W-1:0] req_idx,
  input  logic [TAG_W-1:0] req_tag,
  input  logic [ST_W-1:0]  req_state,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [IDX_W-1:0] rsp_idx,
  output logic [ST_W-1:0]  rsp_state
);
  import tag_cam_pkg::*;

  // reset: asserted asynchronously, released through two flops
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  cam_op_e          op;
  logic [NUM_ENT-1:0] match_vec;
  logic             any_match;
  logic [IDX_W-1:0] hit_idx, lru_idx, rd_idx, touch_idx;
  logic [ST_W-1:0]  rd_st;
  logic             wr_tag_en, wr_st_en, touch_en;

  assign op        = cam_op_e'(req_op);
  assign wr_tag_en = req_valid && (op == OP_WRITE);
  assign wr_st_en  = req_valid && (op == OP_WRITE || op == OP_STWR);
  assign touch_en  = wr_tag_en || (req_valid && op == OP_LOOKUP && any_match);
  assign touch_idx = (op == OP_WRITE) ? req_idx : hit_idx;
  assign rd_idx    = (op == OP_LOOKUP) ? hit_idx : req_idx;

  tag_cam_store #(.N(NUM_ENT), .TW(TAG_W), .SW(ST_W), .IW(IDX_W)) i_store (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_tag_en(wr_tag_en), .wr_st_en(wr_st_en), .wr_idx(req_idx),
    .wr_tag(req_tag), .wr_st(req_state), .cmp_tag(req_tag),
    .match_vec(match_vec), .rd_idx(rd_idx), .rd_st(rd_st)
  );

  tag_cam_prienc #(.N(NUM_ENT), .IW(IDX_W)) i_prienc (
    .match_vec(match_vec), .any_match(any_match), .first_idx(hit_idx)
  );

  tag_cam_order #(.N(NUM_ENT), .IW(IDX_W)) i_order (
    .clk(clk), .rst_n(rst_sync_n),
    .touch_en(touch_en), .touch_idx(touch_idx), .lru_idx(lru_idx)
  );

  // response next-state
  logic             hit_d;
  logic [IDX_W-1:0] idx_d;
  logic [ST_W-1:0]  st_d;
  cam_op_e          rsp_op_q;

  always_comb begin
    hit_d = 1'b0;
    idx_d = req_idx;
    st_d  = req_state;
    unique case (op)
      OP_LOOKUP: begin
        hit_d = any_match;
        idx_d = any_match ? hit_idx : lru_idx;
        st_d  = any_match ? rd_st : '0;
      end
      OP_STRD:  st_d = rd_st;
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_idx   <= '0;
      rsp_state <= '0;
      rsp_op_q  <= OP_LOOKUP;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_hit   <= hit_d;
        rsp_idx   <= idx_d;
        rsp_state <= st_d;
        rsp_op_q  <= op;
      end
    end
  end

  // R2: one response per request, one cycle later
  p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |=> rsp_valid);
  p_rsp_quiet_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid |=> !rsp_valid);
  // R4: a miss carries a zero state
  p_miss_zero_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rsp_valid && rsp_op_q == OP_LOOKUP && !rsp_hit) |-> rsp_state == '0);
  // R3: only lookups report a hit
  p_hit_only_lookup_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rsp_valid && rsp_op_q != OP_LOOKUP) |-> !rsp_hit);
  // R6 / R7 / R8: addressed operations echo the slot index
  p_echo_idx_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && op != OP_LOOKUP) |=> rsp_idx == $past(req_idx));
endmodule

// File: tb/test_tag_cam_lru.sv
module test_tag_cam_lru;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_op;
  logic [3:0]  req_idx;
  logic [31:0] req_tag;
  logic [3:0]  req_state;
  logic        rsp_valid, rsp_hit;
  logic [3:0]  rsp_idx, rsp_state;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tag_cam_lru i_tag_cam_lru (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_idx(req_idx), .req_tag(req_tag), .req_state(req_state),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_idx(rsp_idx),
    .rsp_state(rsp_state)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  // bench model
  logic [31:0] m_tag [N];
  logic [3:0]  m_st  [N];
  int          m_ord [N];

  function automatic void model_reset();
    for (int i = 0; i < N; i++) begin
      m_tag[i] = '0; m_st[i] = '0; m_ord[i] = i;
    end
  endfunction

  function automatic void model_touch(int e);
    int p = 0;
    for (int i = 0; i < N; i++) if (m_ord[i] == e) p = i;
    for (int i = p; i < N - 1; i++) m_ord[i] = m_ord[i+1];
    m_ord[N-1] = e;
  endfunction

  function automatic int model_find(logic [31:0] t);
    for (int i = 0; i < N; i++) if (m_tag[i] == t) return i;
    return -1;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // called at a negedge; leaves at the following negedge after checking
  task automatic do_op(logic [1:0] op, logic [3:0] idx, logic [31:0] tag,
                       logic [3:0] st, string req);
    int e_hit, e_idx, e_st, f;
    req_valid = 1'b1; req_op = op; req_idx = idx; req_tag = tag; req_state = st;
    e_hit = 0; e_idx = idx; e_st = st;
    case (op)
      2'b00: begin
        f = model_find(tag);
        if (f >= 0) begin
          e_hit = 1; e_idx = f; e_st = m_st[f]; model_touch(f);
        end else begin
          e_idx = m_ord[0]; e_st = 0;
        end
      end
      2'b01: begin m_tag[idx] = tag; m_st[idx] = st; model_touch(idx); end
      2'b10: m_st[idx] = st;
      default: e_st = m_st[idx];
    endcase
    @(negedge clk);
    check(req, "rsp_valid", rsp_valid, 1);
    check(req, "rsp_hit",   rsp_hit,   e_hit);
    check(req, "rsp_idx",   rsp_idx,   e_idx);
    check(req, "rsp_state", rsp_state, e_st);
  endtask

  task automatic idle(string req);
    req_valid = 1'b0;
    @(negedge clk);
    check(req, "rsp_valid idle", rsp_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_idx = '0;
    req_tag = '0; req_state = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "rsp_valid after reset", rsp_valid, 0);
    // R1 / R4: miss at reset names slot 0
    do_op(2'b00, 4'd0, 32'hDEAD_BEEF, 4'd0, "R4");
    // R1 / R9: tag 0 sits in every slot, lowest wins
    do_op(2'b00, 4'd0, 32'h0, 4'd0, "R9");
    // R5: slot 0 now most recent, so victim is slot 1
    do_op(2'b00, 4'd0, 32'h1234_5678, 4'd0, "R5");
    idle("R2");
    // R6: fill all slots with distinct tags
    for (int i = 0; i < N; i++)
      do_op(2'b01, 4'(i), 32'hA000_0000 + 32'(i), 4'(i ^ 5), "R6");
    // R3: hit on each slot in reverse order
    for (int i = N - 1; i >= 0; i--)
      do_op(2'b00, 4'd0, 32'hA000_0000 + 32'(i), 4'd0, "R3");
    // R7: state write to the LRU slot must not refresh it
    do_op(2'b10, 4'd15, 32'h0, 4'hC, "R7");
    do_op(2'b00, 4'd0, 32'hFFFF_FFFF, 4'd0, "R7");
    do_op(2'b00, 4'd0, 32'hA000_000F, 4'd0, "R7");
    // R8: state read, then miss shows unchanged order
    do_op(2'b11, 4'd3, 32'h0, 4'd0, "R8");
    do_op(2'b00, 4'd0, 32'hFFFF_FFFE, 4'd0, "R8");
    // R9: duplicate tags, lowest index wins
    do_op(2'b01, 4'd9, 32'hBEEF_0001, 4'd7, "R9");
    do_op(2'b01, 4'd4, 32'hBEEF_0001, 4'd2, "R9");
    do_op(2'b00, 4'd0, 32'hBEEF_0001, 4'd0, "R9");
    idle("R2");
    // random mix over a small tag pool
    for (int k = 0; k < 3000; k++) begin
      logic [1:0] op = 2'($urandom_range(0, 3));
      logic [3:0] ix = 4'($urandom_range(0, 15));
      logic [31:0] tg = 32'hC0DE_0000 + 32'($urandom_range(0, 23));
      logic [3:0] st = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 15) == 0) idle("R2");
      case (op)
        2'b00: do_op(op, ix, tg, st, "R3");
        2'b01: do_op(op, ix, tg, st, "R6");
        2'b10: do_op(op, ix, tg, st, "R7");
        default: do_op(op, ix, tg, st, "R8");
      endcase
    end
    idle("R2");
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule